// File: doc/BRIEF.md
# Clause-22 Serial Management Master

This block runs one clause-22 management transaction on an Ethernet PHY each time it gets a command pulse. It takes a 5-bit PHY address and a packed 25-bit command word. From these it builds a complete frame and clocks it out on a divided management clock (MDC). The data line (MDIO) is tri-stated and is driven through separate output and output-enable pins.

For a read, the block releases the data line at the turnaround. It checks that the PHY answers, then shifts in sixteen data bits. When the frame ends, it raises a done flag. An error flag shows a read that the PHY did not answer.

The command pins and the status pins are plain level and pulse signals. There is no valid/ready handshake on either side. The rules are:
- A one-cycle enable is accepted only while the block is idle.
- While a transaction runs, an enable pulse is dropped and never queued.
- Done and error hold their values until the next accepted command.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `done` is 0, `err` is 0 and `rd_data` is 0.
- R2: While a transaction runs, MDC has a period of 2*HALF_DIV system clocks. The default is 20 clocks, which gives 2.5 MHz from a 50 MHz clock. While idle, MDC stays low.
- R3: The master changes `mdio_o` and `mdio_oe` only on MDC falling edges, and holds them through each MDC high phase. It samples `mdio_i` on MDC rising edges.
- R4: Every frame is 64 MDC cycles long and is sent MSB first, in this order:
  - 32 ones;
  - `cmd_word[24:23]` (start code, 01 in normal use);
  - `cmd_word[22:21]` (opcode);
  - `phy_addr[4:0]`;
  - `cmd_word[20:16]` (register address);
  - 2 turnaround bits;
  - 16 data bits.
- R5: Any opcode other than 10 is a write. The master drives the turnaround as 1 then 0, then sends `cmd_word[15:0]`, and keeps `mdio_oe` high for all 64 bits.
- R6: Opcode 10 is a read. `mdio_oe` is high for bits 0 to 45 and low from bit 46 to the end, so `cmd_word[15:0]` never reaches the line. `rd_data` takes the bits sampled at positions 48 to 63, MSB first, and is valid when `done` rises. A write leaves `rd_data` unchanged.
- R7: If `mdio_i` is high at the rising edge of bit 47 during a read, `err` rises together with `done`. `err` then stays high until the next accepted command. A write or an answered read ends with `err` at 0.
- R8: A one-cycle `cmd_enable` pulse starts a transaction only when the block is idle. Pulses that arrive while a transaction runs are ignored, including a pulse in the cycle the transaction completes. An ignored pulse changes neither the running frame nor MDC.
- R9: `done` rises the cycle after the last MDC falling edge and stays high while the block is idle. In the cycle after an accepted command, `done` and `err` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_enable | input | 1 | One-cycle command launch pulse |
| phy_addr | input | 5 | PHY address placed in the frame |
| cmd_word | input | 25 | {start[1:0], opcode[1:0], register[4:0], write data[15:0]} |
| mdio_i | input | 1 | Sampled management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven value of the data line |
| mdio_oe | output | 1 | 1 = master drives the data line, 0 = released |
| rd_data | output | 16 | Data from the last read |
| done | output | 1 | Transaction finished; block idle |
| err | output | 1 | Last read had no PHY answer at turnaround |

## Verification
Completion of a frame and the arrival of a new enable can fall in the same system clock. A new enable can also arrive while the read data and the error status are being latched. The bench provokes the first case by counting the 64 MDC rising edges and then placing `cmd_enable` exactly HALF_DIV clocks later, on the final falling-edge tick. It judges the result in three steps:
- `done` must read high right after that edge;
- MDC must then stay idle for several bit times;
- a following command, issued normally, must still run as a clean frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int DATA_BITS  = 16;
  localparam int TAIL_BITS  = FRAME_BITS - TA_FIRST;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef struct packed {
    logic [1:0]           st;
    logic [1:0]           op;
    logic [4:0]           reg_addr;
    logic [DATA_BITS-1:0] wdata;
  } mdio_cmd_t;

  typedef enum logic {S_IDLE, S_RUN} ctl_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == CW'(HALF_DIV - 1));
  assign rise_tick = run & wrap & ~mdc;
  assign fall_tick = run & wrap & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_BITS-1:0]  rd_shift,
  output logic                  ta_bad,
  output logic                  last_fall
);
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W:0]        idx_next;
  logic                  rd_mode;

  assign idx_next  = {1'b0, idx} + 1'b1;
  assign last_fall = fall_tick && (idx == IDX_W'(FRAME_BITS - 1));
  assign mdio_o    = shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      idx      <= '0;
      rd_mode  <= 1'b0;
      mdio_oe  <= 1'b0;
      ta_bad   <= 1'b0;
      rd_shift <= '0;
    end else if (load) begin
      shreg   <= frame_in;
      idx     <= '0;
      rd_mode <= is_read;
      mdio_oe <= 1'b1;
      ta_bad  <= 1'b0;
    end else begin
      if (fall_tick) begin
        if (last_fall) begin
          mdio_oe <= 1'b0;
        end else begin
          shreg <= shreg << 1;
          idx   <= idx_next[IDX_W-1:0];
          if (rd_mode && (idx_next >= (IDX_W+1)'(TA_FIRST)))
            mdio_oe <= 1'b0;
        end
      end
      if (rise_tick && rd_mode) begin
        if (idx == IDX_W'(TA_SECOND))
          ta_bad <= mdio_i;
        if (idx >= IDX_W'(DATA_FIRST))
          rd_shift <= {rd_shift[DATA_BITS-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_enable,
  input  logic [4:0]  phy_addr,
  input  logic [24:0] cmd_word,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic        done,
  output logic        err
);
  ctl_state_t            state;
  mdio_cmd_t             cmd;
  logic                  is_read;
  logic                  cur_read;
  logic                  load;
  logic                  run;
  logic                  rise_tick;
  logic                  fall_tick;
  logic                  last_fall;
  logic                  ta_bad;
  logic [DATA_BITS-1:0]  rd_shift;
  logic [FRAME_BITS-1:0] frame;
  logic [TAIL_BITS-1:0]  tail;

  assign cmd     = cmd_word;
  assign is_read = (cmd.op == OP_READ);
  assign load    = (state == S_IDLE) && cmd_enable;
  assign run     = (state == S_RUN);
  assign tail    = is_read ? {TAIL_BITS{1'b1}} : {TA_WRITE, cmd.wdata};
  assign frame   = {{PRE_BITS{1'b1}}, cmd.st, cmd.op, phy_addr, cmd.reg_addr, tail};

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .frame_in  (frame),
    .is_read   (is_read),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_shift  (rd_shift),
    .ta_bad    (ta_bad),
    .last_fall (last_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_read <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      state    <= S_RUN;
      cur_read <= is_read;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (run && last_fall) begin
      state <= S_IDLE;
      done  <= 1'b1;
      err   <= cur_read & ta_bad;
      if (cur_read)
        rd_data <= rd_shift;
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_enable,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic done,
  input logic err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdc && !mdio_oe)); // R2

  AST_HOLD_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> !mdc); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_enable && done) |=> (!done && !err)); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_enable (cmd_enable),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .done       (done),
  .err        (err)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_enable = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [24:0] cmd_word = '0;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, done, err;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .phy_addr(phy_addr),
    .cmd_word(cmd_word), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_data(rd_data), .done(done), .err(err)
  );

  typedef struct packed {
    logic [63:0] frame;
    logic [63:0] mask;
    logic        rd;
    logic [15:0] rdat;
    logic        e;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic        phy_read = 1'b0;
  logic        phy_resp = 1'b1;
  logic [15:0] phy_data = '0;
  logic [15:0] rd_hold = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // PHY model: drives the line after MDC falling edges during reads
  initial begin
    forever begin
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        @(negedge mdc);
        #1;
        if (phy_read && k >= 46 && k < 63) begin
          if (k + 1 == 47) mdio_i = phy_resp ? 1'b0 : 1'b1;
          else             mdio_i = phy_resp ? phy_data[62-k] : 1'b1;
        end else begin
          mdio_i = 1'b1;
        end
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      logic [63:0] got, oeg;
      int t0, holdbad, w;
      exp_t ex;
      holdbad = 0;
      t0 = 0;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        if (k == 0) t0 = cyc;
        if (k == 1) chk("R2", "MDC period", 64'(cyc - t0), 64'(2 * HALF));
        #1;
        got[63-k] = mdio_o;
        oeg[63-k] = mdio_oe;
        #(HALF * 5 - 3);
        if (mdio_o !== got[63-k] || mdio_oe !== oeg[63-k]) holdbad++;
      end
      w = 0;
      while (!done && w < 200) begin @(negedge clk); w++; end
      chk("R9", "done after frame", 64'(done), 64'd1);
      chk("R3", "hold in high phase", 64'(holdbad), 64'd0);
      if (q.size() == 0) begin
        chk("R8", "unexpected frame", 64'd1, 64'd0);
      end else begin
        ex = q.pop_front();
        chk(ex.rd ? "R4" : "R5", "frame bits", got & ex.mask, ex.frame & ex.mask);
        chk(ex.rd ? "R6" : "R5", "drive enable", oeg, ex.mask);
        chk(ex.rd ? "R6 R3" : "R6", "rd_data", 64'(rd_data), 64'(ex.rdat));
        chk("R7", "err", 64'(err), 64'(ex.e));
      end
    end
  end

  task automatic push_exp(input logic [4:0] pa, input logic [24:0] cw,
                          input logic resp, input logic [15:0] pdat);
    exp_t ex;
    ex.rd    = (cw[22:21] == 2'b10);
    ex.frame = {32'hFFFF_FFFF, cw[24:23], cw[22:21], pa, cw[20:16],
                ex.rd ? 18'h0 : {2'b10, cw[15:0]}};
    ex.mask  = ex.rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    if (ex.rd) rd_hold = resp ? pdat : 16'hFFFF;
    ex.rdat  = rd_hold;
    ex.e     = ex.rd & ~resp;
    q.push_back(ex);
    phy_read = ex.rd;
    phy_resp = resp;
    phy_data = pdat;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [4:0] pa, input logic [24:0] cw,
                       input logic resp, input logic [15:0] pdat, input int extra_at);
    push_exp(pa, cw, resp, pdat);
    @(negedge clk);
    cmd_enable = 1'b1; phy_addr = pa; cmd_word = cw;
    @(negedge clk);
    cmd_enable = 1'b0;
    chk("R9", "done low after start", 64'(done), 64'd0);
    chk("R7", "err cleared at start", 64'(err), 64'd0);
    if (extra_at > 0) begin
      repeat (extra_at) @(negedge clk);
      cmd_enable = 1'b1; phy_addr = 5'h1E; cmd_word = 25'h0FF_FFFF;
      @(negedge clk);
      cmd_enable = 1'b0; phy_addr = pa; cmd_word = cw;
    end
    wait_done();
  endtask

  task automatic idle_window(input string req);
    int bad = 0;
    for (int i = 0; i < 6 * HALF; i++) begin
      @(negedge clk);
      if (mdc !== 1'b0 || done !== 1'b1) bad++;
    end
    chk(req, "stays idle", 64'(bad), 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mdc reset", 64'(mdc), 64'd0);
    chk("R1", "oe reset", 64'(mdio_oe), 64'd0);
    chk("R1", "done reset", 64'(done), 64'd0);
    chk("R1", "err reset", 64'(err), 64'd0);
    chk("R1", "rd_data reset", 64'(rd_data), 64'd0);

    // write: start 01, op 01, reg 0A, data A5C3
    issue(5'h11, {2'b01, 2'b01, 5'h0A, 16'hA5C3}, 1'b1, 16'h0, 0);
    // read with nonzero write field (ignored), PHY answers
    issue(5'h03, {2'b01, 2'b10, 5'h1F, 16'h1234}, 1'b1, 16'h3C5A, 0);
    issue(5'h00, {2'b01, 2'b10, 5'h00, 16'hFFFF}, 1'b1, 16'h8001, 0);
    // read with no PHY answer
    issue(5'h07, {2'b01, 2'b10, 5'h05, 16'h0000}, 1'b0, 16'h0, 0);
    idle_window("R7");
    chk("R7", "err sticky while idle", 64'(err), 64'd1);
    // write with an ignored enable mid-frame; also clears err
    issue(5'h15, {2'b01, 2'b01, 5'h13, 16'h5AA5}, 1'b1, 16'h0, 400);
    idle_window("R8");
    chk("R6", "write keeps rd_data", 64'(rd_data), 64'(rd_hold));

    // enable in the completion cycle must be ignored
    push_exp(5'h09, {2'b01, 2'b01, 5'h02, 16'h0F0F}, 1'b1, 16'h0);
    @(negedge clk);
    cmd_enable = 1'b1; phy_addr = 5'h09; cmd_word = {2'b01, 2'b01, 5'h02, 16'h0F0F};
    @(negedge clk);
    cmd_enable = 1'b0;
    repeat (64) @(posedge mdc);
    repeat (HALF) @(negedge clk);
    cmd_enable = 1'b1; cmd_word = {2'b01, 2'b10, 5'h04, 16'h0};
    @(negedge clk);
    cmd_enable = 1'b0;
    chk("R8", "done at completion-cycle enable", 64'(done), 64'd1);
    idle_window("R8");

    // command right after done is accepted
    issue(5'h1C, {2'b01, 2'b10, 5'h11, 16'h0}, 1'b1, 16'hC0DE, 0);
    chk("R6", "final rd_data", 64'(rd_data), 64'hC0DE);
    chk("R8", "no leftover frames", 64'(q.size()), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule